// File: doc/BRIEF.md
# Smart Card Character Transceiver with Automatic Retransmission

This block moves single characters in both directions over one shared open-drain data wire, one direction at a time. It never drives the wire high. To drive it low it raises an output enable, and it reads the wire back through a sampled input. An external pull-up holds the released wire high. Each character is one low start bit, eight data bits sent least significant first, and one even parity bit.

The receiver checks parity on every character. If the parity is wrong, it pulls the wire low for one elementary time unit (etu) so that the far end knows to resend. The transmitter watches the wire in that same window after each character it sends. If it sees a low, it resends the same character on its own, up to a set number of times. When that number runs out, it reports the character as failed and raises a sticky error flag. That flag stays set until it is cleared explicitly.

All timing comes from a sub-etu tick input that pulses `SUBS` times per etu. Bits are sampled at mid-etu. A frame with its guard time lasts 12 etu. The transmitter accepts a byte through a valid/ready handshake. The receiver presents each good byte with a one-cycle valid pulse.

Top module: `sc_char_xcvr`

## Requirements
- R1: After reset the wire is released (`line_oe`=0), `tx_ready`=1, and `tx_err`, `rx_valid`, `rx_perr`, `tx_done`, `tx_fail` and `tx_retry` are all 0. `line_oe` changes only on a clock edge where `etu_tick` is high.
- R2: A transmitted frame holds one bit per etu, in this order: bit 0 is the start bit (low), bits 1 to 8 are data bits D0 to D7, and bit 9 is the parity bit. The parity makes the total number of ones among the data and parity bits even. From 10 etu after the frame start the wire is released.
- R3: A received frame with correct even parity gives one `rx_valid` pulse carrying the byte on `rx_data`. This happens on the sub-tick 10.5 etu after the first sub-tick that saw the start bit low. No error pulse is driven.
- R4: A received frame with wrong parity gives no `rx_valid`. It gives one `rx_perr` pulse and drives the wire low for exactly `SUBS` sub-ticks, starting 10.5 etu after the start bit was seen.
- R5: The transmitter samples the wire 11 etu after its frame start. If it sees a low, it pulses `tx_retry` and restarts the same character exactly 12 etu after the previous start, which leaves a 2 etu guard after the parity bit.
- R6: After `RETRY_MAX` retransmissions (default 3, so 4 frames) that are all refused, the transmitter pulses `tx_fail`, sends nothing more, and sets `tx_err`. `tx_err` stays 1 through later successful characters and clears only on `tx_err_clr`.
- R7: A low on the wire that has ended by mid-etu of the start bit is a glitch. It produces no byte, no error pulse and no drive, and the next real frame is received normally.
- R8: While a character is being transmitted, the receiver ignores the wire. Neither the block's own frame nor an error pulse from the far end produces `rx_valid`, and the receiver never drives the wire at the same time as the transmitter.
- R9: A character that is not refused ends with one `tx_done` pulse, no `tx_retry`, and `tx_ready` high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| etu_tick | input | 1 | One-cycle pulse, SUBS per etu |
| line_in | input | 1 | Sampled level of the shared wire |
| line_oe | output | 1 | 1 pulls the wire low, 0 releases it |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter can take a byte |
| tx_done | output | 1 | Pulse: character sent and not refused |
| tx_fail | output | 1 | Pulse: character abandoned after the retry limit |
| tx_retry | output | 1 | Pulse: retransmission starting |
| tx_err | output | 1 | Sticky transmit failure flag |
| tx_err_clr | input | 1 | Clears tx_err |
| rx_valid | output | 1 | Pulse: good byte received |
| rx_data | output | 8 | Received byte |
| rx_perr | output | 1 | Pulse: parity error, error signal being driven |

## Verification
Every result counts in sub-ticks from the first sub-tick at which the start bit is low. A received byte or parity error reports 84 sub-ticks after that point (10.5 etu at `SUBS`=8). The error pulse covers the next 8 sub-ticks. The transmitter's refusal sample falls at 88, and a retransmission starts at 96. The bench counts sub-ticks itself from the start it drives or observes, samples 1 ns after each clock edge that carries a tick, and compares the exact tick index at which each pulse or wire level appears.

// File: rtl/sc_xcvr_pkg.sv
package sc_xcvr_pkg;

    localparam int DATA_W      = 8;
    localparam int FRAME_W     = DATA_W + 2;   // start + data + parity
    localparam int ERR_ETU     = FRAME_W;      // error window opens half an etu past this
    localparam int SAMP_ETU    = FRAME_W + 1;  // transmitter looks for refusal here
    localparam int FRAME_ETU   = FRAME_W + 2;  // full slot including guard

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_BUSY,
        RX_ERR
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_WAIT,
        TX_SEND
    } tx_state_e;

    typedef struct packed {
        logic              par;
        logic [DATA_W-1:0] data;
        logic              start;
    } frame_t;

    function automatic frame_t build_frame(input logic [DATA_W-1:0] d);
        frame_t f;
        f.start = 1'b0;
        f.data  = d;
        f.par   = ^d;
        return f;
    endfunction

    function automatic logic parity_good(input logic [DATA_W:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/sc_rx.sv
module sc_rx
    import sc_xcvr_pkg::*;
#(
    parameter int SUBS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic              line,
    output logic              drive,
    output logic              valid,
    output logic              perr,
    output logic              busy,
    output logic [DATA_W-1:0] data
);

    localparam int QW = $clog2(FRAME_ETU * SUBS + 1);
    localparam logic [QW-1:0] Q_S       = QW'(SUBS);
    localparam logic [QW-1:0] Q_MID     = QW'(SUBS / 2);
    localparam logic [QW-1:0] Q_ERR_ON  = QW'(ERR_ETU * SUBS + SUBS / 2);
    localparam logic [QW-1:0] Q_ERR_OFF = QW'((ERR_ETU + 1) * SUBS + SUBS / 2);

    rx_state_e         st;
    logic [QW-1:0]     q;
    logic [QW-1:0]     qn;
    logic [DATA_W:0]   sh;
    logic              bit_samp;

    assign qn       = q + QW'(1);
    assign busy     = (st != RX_IDLE);
    assign bit_samp = (qn > Q_MID) && (qn < Q_ERR_ON) && ((qn % Q_S) == Q_MID);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RX_IDLE;
            q     <= '0;
            sh    <= '0;
            drive <= 1'b0;
            valid <= 1'b0;
            perr  <= 1'b0;
            data  <= '0;
        end else begin
            valid <= 1'b0;
            perr  <= 1'b0;
            if (tick) begin
                unique case (st)
                    RX_IDLE: begin
                        if (en && !line) begin
                            st <= RX_BUSY;
                            q  <= '0;
                        end
                    end
                    RX_BUSY: begin
                        q <= qn;
                        if (qn == Q_MID && line) begin
                            st <= RX_IDLE;
                        end else if (bit_samp) begin
                            sh <= {line, sh[DATA_W:1]};
                        end else if (qn == Q_ERR_ON) begin
                            if (parity_good(sh)) begin
                                valid <= 1'b1;
                                data  <= sh[DATA_W-1:0];
                                st    <= RX_IDLE;
                            end else begin
                                perr  <= 1'b1;
                                drive <= 1'b1;
                                st    <= RX_ERR;
                            end
                        end
                    end
                    RX_ERR: begin
                        q <= qn;
                        if (qn == Q_ERR_OFF) begin
                            drive <= 1'b0;
                            st    <= RX_IDLE;
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/sc_tx.sv
module sc_tx
    import sc_xcvr_pkg::*;
#(
    parameter int SUBS      = 8,
    parameter int RETRY_MAX = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              line,
    input  logic              rx_busy,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              err_clr,
    output logic              ready,
    output logic              idle,
    output logic              drive,
    output logic              done,
    output logic              fail,
    output logic              retry,
    output logic              err
);

    localparam int QW = $clog2(FRAME_ETU * SUBS + 1);
    localparam int RW = $clog2(RETRY_MAX + 1) < 1 ? 1 : $clog2(RETRY_MAX + 1);
    localparam logic [QW-1:0] Q_S     = QW'(SUBS);
    localparam logic [QW-1:0] Q_SAMP  = QW'(SAMP_ETU * SUBS);
    localparam logic [QW-1:0] Q_FRAME = QW'(FRAME_ETU * SUBS);
    localparam logic [RW-1:0] R_MAX   = RW'(RETRY_MAX);

    tx_state_e           st;
    frame_t              fr;
    logic [FRAME_W-1:0]  sh;
    logic [QW-1:0]       q;
    logic [QW-1:0]       qn;
    logic [RW-1:0]       tries;
    logic                nack;

    assign qn    = q + QW'(1);
    assign ready = (st == TX_IDLE);
    assign idle  = (st == TX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= TX_IDLE;
            fr    <= '1;
            sh    <= '1;
            q     <= '0;
            tries <= '0;
            nack  <= 1'b0;
            drive <= 1'b0;
            done  <= 1'b0;
            fail  <= 1'b0;
            retry <= 1'b0;
            err   <= 1'b0;
        end else begin
            done  <= 1'b0;
            fail  <= 1'b0;
            retry <= 1'b0;
            if (err_clr) err <= 1'b0;
            unique case (st)
                TX_IDLE: begin
                    if (in_valid) begin
                        fr    <= build_frame(in_data);
                        tries <= '0;
                        st    <= TX_WAIT;
                    end
                end
                TX_WAIT: begin
                    if (tick && !rx_busy) begin
                        st    <= TX_SEND;
                        q     <= '0;
                        sh    <= fr;
                        drive <= 1'b1;
                        nack  <= 1'b0;
                    end
                end
                TX_SEND: begin
                    if (tick) begin
                        q <= qn;
                        if ((qn % Q_S) == '0) begin
                            drive <= ~sh[1];
                            sh    <= {1'b1, sh[FRAME_W-1:1]};
                        end
                        if (qn == Q_SAMP && !line) nack <= 1'b1;
                        if (qn == Q_FRAME) begin
                            if (!nack) begin
                                done <= 1'b1;
                                st   <= TX_IDLE;
                            end else if (tries == R_MAX) begin
                                fail <= 1'b1;
                                err  <= 1'b1;
                                st   <= TX_IDLE;
                            end else begin
                                tries <= tries + RW'(1);
                                retry <= 1'b1;
                                q     <= '0;
                                sh    <= fr;
                                drive <= 1'b1;
                                nack  <= 1'b0;
                            end
                        end
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr
    import sc_xcvr_pkg::*;
#(
    parameter int SUBS      = 8,
    parameter int RETRY_MAX = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       etu_tick,
    input  logic       line_in,
    output logic       line_oe,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       tx_done,
    output logic       tx_fail,
    output logic       tx_retry,
    output logic       tx_err,
    input  logic       tx_err_clr,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_perr
);

    logic rx_drive;
    logic tx_drive;
    logic rx_busy;
    logic tx_idle;

    sc_rx #(.SUBS(SUBS)) rx_i (
        .clk   (clk),
        .rst   (rst),
        .tick  (etu_tick),
        .en    (tx_idle),
        .line  (line_in),
        .drive (rx_drive),
        .valid (rx_valid),
        .perr  (rx_perr),
        .busy  (rx_busy),
        .data  (rx_data)
    );

    sc_tx #(.SUBS(SUBS), .RETRY_MAX(RETRY_MAX)) tx_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (etu_tick),
        .line     (line_in),
        .rx_busy  (rx_busy),
        .in_valid (tx_valid),
        .in_data  (tx_data),
        .err_clr  (tx_err_clr),
        .ready    (tx_ready),
        .idle     (tx_idle),
        .drive    (tx_drive),
        .done     (tx_done),
        .fail     (tx_fail),
        .retry    (tx_retry),
        .err      (tx_err)
    );

    assign line_oe = rx_drive | tx_drive;

endmodule

// File: rtl/sc_char_xcvr_chk.sv
module sc_char_xcvr_chk (
    input logic clk,
    input logic rst,
    input logic etu_tick,
    input logic line_oe,
    input logic rx_drive,
    input logic tx_drive,
    input logic rx_busy,
    input logic rx_valid,
    input logic rx_perr,
    input logic tx_done,
    input logic tx_fail,
    input logic tx_retry,
    input logic tx_err,
    input logic tx_err_clr
);

    a_r1_oe_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        (line_oe != $past(line_oe)) |-> $past(etu_tick));

    a_r3_valid_not_with_perr: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_perr));

    a_r4_perr_drives_line: assert property (@(posedge clk) disable iff (rst)
        rx_perr |-> rx_drive);

    a_r5_retry_alone: assert property (@(posedge clk) disable iff (rst)
        tx_retry |-> (!tx_done && !tx_fail));

    a_r6_fail_sets_err: assert property (@(posedge clk) disable iff (rst)
        tx_fail |=> tx_err);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (tx_err && !tx_err_clr) |=> tx_err);

    a_r8_single_driver: assert property (@(posedge clk) disable iff (rst)
        !(rx_drive && tx_drive));

    a_r8_rx_quiet_while_tx: assert property (@(posedge clk) disable iff (rst)
        tx_drive |-> (!rx_busy && !rx_valid));

endmodule

bind sc_char_xcvr sc_char_xcvr_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .etu_tick   (etu_tick),
    .line_oe    (line_oe),
    .rx_drive   (rx_drive),
    .tx_drive   (tx_drive),
    .rx_busy    (rx_busy),
    .rx_valid   (rx_valid),
    .rx_perr    (rx_perr),
    .tx_done    (tx_done),
    .tx_fail    (tx_fail),
    .tx_retry   (tx_retry),
    .tx_err     (tx_err),
    .tx_err_clr (tx_err_clr)
);

// File: tb/sc_char_xcvr_tb_top.sv
`timescale 1ns/1ps
module sc_char_xcvr_tb_top;

    localparam int S    = 8;
    localparam int TDIV = 4;

    // {flip_parity, data}
    localparam logic [8:0] RXV [6] = '{
        {1'b0, 8'hA5}, {1'b0, 8'h00}, {1'b0, 8'hFF},
        {1'b1, 8'h3C}, {1'b1, 8'h01}, {1'b0, 8'h80}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       etu_tick = 1'b0;
    logic       bdrv = 1'b0;
    logic       line_in;
    logic       line_oe;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_ready, tx_done, tx_fail, tx_retry, tx_err;
    logic       tx_err_clr = 1'b0;
    logic       rx_valid, rx_perr;
    logic [7:0] rx_data;

    int checks = 0;
    int failures = 0;
    int div = 0;

    int v_r, p_r, oe_first, oe_cnt;
    logic [7:0] v_d;
    int frames, retries, dn, fl, rxv;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        etu_tick <= (div == 0);
        div      <= (div == TDIV - 1) ? 0 : div + 1;
    end

    assign line_in = ~(line_oe | bdrv);

    sc_char_xcvr #(.SUBS(S), .RETRY_MAX(3)) dut_i (
        .clk(clk), .rst(rst), .etu_tick(etu_tick), .line_in(line_in),
        .line_oe(line_oe), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .tx_done(tx_done), .tx_fail(tx_fail),
        .tx_retry(tx_retry), .tx_err(tx_err), .tx_err_clr(tx_err_clr),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tk();
        do @(posedge clk); while (!etu_tick);
        #1;
    endtask

    task automatic rx_frame(input logic [7:0] d, input bit flip, input int glen);
        logic [9:0] fr;
        fr = {(^d) ^ flip, d, 1'b0};
        v_r = -1; p_r = -1; oe_first = -1; oe_cnt = 0; v_d = '0;
        bdrv = 1'b1;
        for (int r = 1; r <= 14 * S; r++) begin
            tk();
            if (rx_valid && v_r < 0) begin v_r = r; v_d = rx_data; end
            if (rx_perr && p_r < 0) p_r = r;
            if (line_oe) begin
                oe_cnt++;
                if (oe_first < 0) oe_first = r;
            end
            if (glen > 0) bdrv = (r < glen);
            else          bdrv = (r < 10 * S) ? ~fr[r / S] : 1'b0;
        end
        bdrv = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        while (!tx_ready) begin @(posedge clk); #1; end
        tx_valid = 1'b1;
        tx_data  = d;
        @(posedge clk); #1;
        tx_valid = 1'b0;
    endtask

    task automatic tx_watch(input logic [7:0] d, input logic [3:0] nmask);
        int r, t, last_start, post;
        logic [9:0] bits;
        frames = 0; retries = 0; dn = 0; fl = 0; rxv = 0;
        r = -1; t = 0; last_start = 0; post = 0; bits = '0;
        for (int n = 0; n < 800 && post < 20; n++) begin
            tk();
            t++;
            if (tx_retry) retries++;
            if (tx_done)  dn++;
            if (tx_fail)  fl++;
            if (rx_valid) rxv++;
            if (dn > 0 || fl > 0) post++;
            if (r < 0) begin
                if (line_oe) begin
                    r = 0;
                    if (frames > 0)
                        chk(t - last_start == 12 * S, "R5 restart spacing", t - last_start, 12 * S);
                    last_start = t;
                    frames++;
                end
            end else begin
                r++;
                if ((r % S) == S / 2 && r < 10 * S) bits[r / S] = line_in;
                if (r == 10 * S + S / 2) begin
                    chk(line_in == 1'b1, "R2 released after parity", int'(line_in), 1);
                    chk(bits == {^d, d, 1'b0}, "R2 frame bits", int'(bits), int'({^d, d, 1'b0}));
                    bdrv = (frames >= 1 && frames <= 4) ? nmask[frames - 1] : 1'b0;
                end
                if (r == 11 * S + S / 2) bdrv = 1'b0;
                if (r == 12 * S - 1) r = -1;
            end
        end
        bdrv = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (6) @(posedge clk);
        #1 rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(line_oe == 1'b0, "R1 oe after reset", int'(line_oe), 0);
        chk(tx_ready == 1'b1, "R1 tx_ready after reset", int'(tx_ready), 1);
        chk(tx_err == 1'b0, "R1 tx_err after reset", int'(tx_err), 0);
        chk(rx_valid == 1'b0 && rx_perr == 1'b0, "R1 rx flags after reset",
            int'({rx_valid, rx_perr}), 0);
        chk({tx_done, tx_fail, tx_retry} == 3'b000, "R1 tx pulses after reset",
            int'({tx_done, tx_fail, tx_retry}), 0);

        // Vector walk: R3 good frames, R4 bad parity
        foreach (RXV[i]) begin
            rx_frame(RXV[i][7:0], RXV[i][8], 0);
            if (!RXV[i][8]) begin
                chk(v_r == 85, "R3 rx_valid tick", v_r, 85);
                chk(v_d == RXV[i][7:0], "R3 rx_data", int'(v_d), int'(RXV[i][7:0]));
                chk(p_r < 0 && oe_cnt == 0, "R3 no error pulse", oe_cnt, 0);
            end else begin
                chk(v_r < 0, "R4 no rx_valid", v_r, -1);
                chk(p_r == 85, "R4 rx_perr tick", p_r, 85);
                chk(oe_first == 85, "R4 error pulse start", oe_first, 85);
                chk(oe_cnt == S, "R4 error pulse width", oe_cnt, S);
            end
            repeat (4) tk();
        end

        // R7 glitch then real frame
        rx_frame(8'h55, 1'b0, 2);
        chk(v_r < 0 && p_r < 0, "R7 glitch gives no byte", v_r, -1);
        chk(oe_cnt == 0, "R7 glitch gives no drive", oe_cnt, 0);
        rx_frame(8'h55, 1'b0, 0);
        chk(v_r == 85 && v_d == 8'h55, "R7 frame after glitch", int'(v_d), 'h55);

        // R9 / R2 / R8 clean transmit
        send(8'hC3);
        tx_watch(8'hC3, 4'b0000);
        chk(frames == 1, "R9 single frame", frames, 1);
        chk(dn == 1 && retries == 0, "R9 tx_done once", dn, 1);
        chk(tx_err == 1'b0, "R9 no error flag", int'(tx_err), 0);
        chk(tx_ready == 1'b1, "R9 ready again", int'(tx_ready), 1);
        chk(rxv == 0, "R8 rx silent during tx", rxv, 0);

        // R5 one refusal
        send(8'h5A);
        tx_watch(8'h5A, 4'b0001);
        chk(frames == 2, "R5 frames with one refusal", frames, 2);
        chk(retries == 1 && dn == 1, "R5 retry then done", retries, 1);
        chk(rxv == 0, "R8 rx ignores far-end error pulse", rxv, 0);

        // R6 all refused
        send(8'h96);
        tx_watch(8'h96, 4'b1111);
        chk(frames == 4, "R6 frames before giving up", frames, 4);
        chk(retries == 3, "R6 retries", retries, 3);
        chk(fl == 1 && dn == 0, "R6 tx_fail once", fl, 1);
        chk(tx_err == 1'b1, "R6 tx_err set", int'(tx_err), 1);

        // R6 sticky through a good character, then cleared
        send(8'h11);
        tx_watch(8'h11, 4'b0000);
        chk(dn == 1, "R6 later character done", dn, 1);
        chk(tx_err == 1'b1, "R6 tx_err still set", int'(tx_err), 1);
        tx_err_clr = 1'b1;
        @(posedge clk); #1;
        tx_err_clr = 1'b0;
        chk(tx_err == 1'b0, "R6 tx_err cleared", int'(tx_err), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule